// File: doc/BRIEF.md
# Colour Lookup Palette with Host Register Window

This block turns 8-bit pixel indices into packed colour words for an indexed frame buffer. It keeps 256 palette entries, each holding an 8-bit red, an 8-bit green and an 8-bit blue value. Pixel lookups are served through a registered port. The output word is packed into one of four depths, chosen per lookup: 8-bit, 15-bit, 16-bit or 32-bit.

The host loads colours through a 16-byte window of four word registers, using plain 32-bit writes. The host first writes the entry number to the index register. It then writes three values to the colour register, and an internal sequencer sends them to red, green and blue in that order. After blue, the sequencer moves to the next entry. One index write followed by 768 colour writes therefore fills the whole table. Reset loads a default palette in which every entry is black except the last, which is white.

Top module: `clut_dac`

## Requirements
- R1: The palette has 256 entries of 8-bit red, green and blue. After reset, entries 0 to 254 read as all zero and entry 255 reads as all 0xFF.
- R2: The register is chosen by address bits 3:2, and address bits 1:0 are ignored. A write to register 0 loads the entry index from write-data bits 31:24 and returns the colour sequencer to red.
- R3: Writes to register 1 store write-data bits 31:24 into the current entry's red, then green, then blue component, one component per write.
- R4: After the blue write, the sequencer returns to red and the entry index increases by one, wrapping from 255 to 0.
- R5: Writes to registers 2 and 3 change neither the palette, the index nor the sequencer. The read data port is always zero.
- R6: Format code 0 (8-bit) packs red[7:5] into bits 7:5, green[7:5] into bits 4:2 and blue[7:6] into bits 1:0. All higher bits are zero.
- R7: Format code 1 (15-bit) packs red[7:3], green[7:3] and blue[7:3] into bits 14:10, 9:5 and 4:0. All higher bits are zero.
- R8: Format code 2 (16-bit) packs red[7:3] into bits 15:11, green[7:2] into bits 10:5 and blue[7:3] into bits 4:0. All higher bits are zero.
- R9: Format code 3 (32-bit) places red at bits 23:16, green at bits 15:8 and blue at bits 7:0. Bits 31:24 are zero.
- R10: The packed colour appears exactly one clock after the index and format are presented. It holds while the index, the format and the addressed entry are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 4 | Byte address within the register window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, always zero |
| pix_idx | input | 8 | Pixel index to look up |
| pix_fmt | input | 2 | Output depth code: 0 = 8-bit, 1 = 15-bit, 2 = 16-bit, 3 = 32-bit |
| pix_color | output | 32 | Registered packed colour |

## Verification
The assertions watch the register path on every cycle:
- an index write loads the index and returns the sequencer to red;
- at most one component strobe fires at a time, and it matches the sequencer state;
- a blue write advances and wraps the index;
- writes to the spare registers leave the sequencer alone;
- the pixel output holds when nothing it depends on changes.

Only the bench's scenarios can show the rest:
- the stored colour values and the reset palette contents;
- the bit layout of the four packed formats;
- the exact one-cycle delay of the lookup;
- that spare-register writes leave no trace in the palette.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int COMP_W = 8;
  localparam int PIX_W  = 32;

  typedef enum logic [1:0] {
    FMT_8  = 2'd0,
    FMT_15 = 2'd1,
    FMT_16 = 2'd2,
    FMT_32 = 2'd3
  } pix_fmt_e;

  typedef enum logic [1:0] {
    SEQ_RED = 2'd0,
    SEQ_GRN = 2'd1,
    SEQ_BLU = 2'd2
  } seq_e;

  // register numbers inside the window (address bits 3:2)
  localparam logic [1:0] REG_INDEX = 2'd0;
  localparam logic [1:0] REG_COLOR = 2'd1;

  function automatic logic [PIX_W-1:0] pack_8(logic [COMP_W-1:0] r,
                                              logic [COMP_W-1:0] g,
                                              logic [COMP_W-1:0] b);
    logic [PIX_W-1:0] r32, g32, b32;
    r32 = PIX_W'(r); g32 = PIX_W'(g); b32 = PIX_W'(b);
    return ((r32 >> 5) << 5) | ((g32 >> 5) << 2) | (b32 >> 6);
  endfunction

  function automatic logic [PIX_W-1:0] pack_15(logic [COMP_W-1:0] r,
                                               logic [COMP_W-1:0] g,
                                               logic [COMP_W-1:0] b);
    logic [PIX_W-1:0] r32, g32, b32;
    r32 = PIX_W'(r); g32 = PIX_W'(g); b32 = PIX_W'(b);
    return ((r32 >> 3) << 10) | ((g32 >> 3) << 5) | (b32 >> 3);
  endfunction

  function automatic logic [PIX_W-1:0] pack_16(logic [COMP_W-1:0] r,
                                               logic [COMP_W-1:0] g,
                                               logic [COMP_W-1:0] b);
    logic [PIX_W-1:0] r32, g32, b32;
    r32 = PIX_W'(r); g32 = PIX_W'(g); b32 = PIX_W'(b);
    return ((r32 >> 3) << 11) | ((g32 >> 2) << 5) | (b32 >> 3);
  endfunction

  function automatic logic [PIX_W-1:0] pack_32(logic [COMP_W-1:0] r,
                                               logic [COMP_W-1:0] g,
                                               logic [COMP_W-1:0] b);
    logic [PIX_W-1:0] r32, g32, b32;
    r32 = PIX_W'(r); g32 = PIX_W'(g); b32 = PIX_W'(b);
    return (r32 << 16) | (g32 << 8) | b32;
  endfunction

  function automatic logic [PIX_W-1:0] pack_pixel(pix_fmt_e fmt,
                                                  logic [COMP_W-1:0] r,
                                                  logic [COMP_W-1:0] g,
                                                  logic [COMP_W-1:0] b);
    case (fmt)
      FMT_8:   return pack_8(r, g, b);
      FMT_15:  return pack_15(r, g, b);
      FMT_16:  return pack_16(r, g, b);
      default: return pack_32(r, g, b);
    endcase
  endfunction

endpackage

// File: rtl/clut_regif.sv
module clut_regif
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output seq_e              seq_q,
  output logic [2:0]        comp_we,
  output logic [COMP_W-1:0] comp_val
);

  localparam int SEL_LSB = 2;

  logic [1:0] reg_sel;
  logic       wr_index;
  logic       wr_color;
  logic       unused_bits;

  assign reg_sel     = bus_addr[SEL_LSB+1:SEL_LSB];
  assign wr_index    = bus_we && (reg_sel == REG_INDEX);
  assign wr_color    = bus_we && (reg_sel == REG_COLOR);
  assign comp_val    = bus_wdata[DATA_W-1 -: COMP_W];
  assign unused_bits = ^{bus_addr[SEL_LSB-1:0], bus_wdata[DATA_W-COMP_W-1:0]};

  // one strobe per component: bit 0 red, bit 1 green, bit 2 blue
  always_comb begin
    comp_we = '0;
    if (wr_color) begin
      case (seq_q)
        SEQ_RED: comp_we[0] = 1'b1;
        SEQ_GRN: comp_we[1] = 1'b1;
        SEQ_BLU: comp_we[2] = 1'b1;
        default: comp_we    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      seq_q <= SEQ_RED;
    end else if (wr_index) begin
      idx_q <= bus_wdata[DATA_W-1 -: IDX_W];
      seq_q <= SEQ_RED;
    end else if (wr_color) begin
      case (seq_q)
        SEQ_RED: seq_q <= SEQ_GRN;
        SEQ_GRN: seq_q <= SEQ_BLU;
        default: begin
          seq_q <= SEQ_RED;
          idx_q <= idx_q + IDX_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             comp_we,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [COMP_W-1:0]      comp_val,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [2:0][COMP_W-1:0] rd_rgb
);

  localparam int DEPTH = 1 << IDX_W;

  // one table per component; index 0 red, 1 green, 2 blue
  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (i == DEPTH - 1) ? {COMP_W{1'b1}} : '0;
      end else if (comp_we[c]) begin
        mem[wr_idx] <= comp_val;
      end
    end

    assign rd_rgb[c] = mem[rd_idx];
  end

endmodule

// File: rtl/clut_pack.sv
module clut_pack
  import clut_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0][COMP_W-1:0] rgb,
  input  logic [1:0]             fmt,
  output logic [PIX_W-1:0]       pix_color
);

  always_ff @(posedge clk) begin
    if (!rst_n) pix_color <= '0;
    else        pix_color <= pack_pixel(pix_fmt_e'(fmt), rgb[0], rgb[1], rgb[2]);
  end

endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic [1:0]        pix_fmt,
  output logic [PIX_W-1:0]  pix_color
);

  logic [IDX_W-1:0]       idx_q;
  seq_e                   seq_q;
  logic [2:0]             comp_we;
  logic [COMP_W-1:0]      comp_val;
  logic [2:0][COMP_W-1:0] rd_rgb;

  assign bus_rdata = '0;

  clut_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .idx_q    (idx_q),
    .seq_q    (seq_q),
    .comp_we  (comp_we),
    .comp_val (comp_val)
  );

  clut_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .comp_we (comp_we),
    .wr_idx  (idx_q),
    .comp_val(comp_val),
    .rd_idx  (pix_idx),
    .rd_rgb  (rd_rgb)
  );

  clut_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .rgb      (rd_rgb),
    .fmt      (pix_fmt),
    .pix_color(pix_color)
  );

endmodule

// File: rtl/clut_dac_chk.sv
module clut_dac_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        seq_q,
  input logic [2:0]        comp_we,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [1:0]        pix_fmt,
  input logic [31:0]       pix_color
);

  logic [1:0] sel;
  assign sel = bus_addr[3:2];

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd0) |=>
      (idx_q == $past(bus_wdata[DATA_W-1 -: IDX_W]) && seq_q == 2'd0));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  assert_strobe_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd1) |->
      comp_we == (3'b001 << seq_q));

  assert_blue_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == 2'd1 && seq_q == 2'd2) |=>
      (seq_q == 2'd0 && idx_q == $past(idx_q) + IDX_W'(1)));

  assert_spare_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel[1]) |-> (comp_we == 3'b000 ##1 ($stable(idx_q) && $stable(seq_q))));

  assert_output_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(pix_idx) && $stable(pix_fmt) && $past(comp_we) == 3'b000) |=>
      $stable(pix_color));

endmodule

bind clut_dac clut_dac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .idx_q    (idx_q),
  .seq_q    (seq_q),
  .comp_we  (comp_we),
  .pix_idx  (pix_idx),
  .pix_fmt  (pix_fmt),
  .pix_color(pix_color)
);

// File: tb/clut_dac_bench.sv
`timescale 1ns/1ps
module clut_dac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [1:0]  pix_fmt = '0;
  logic [31:0] pix_color;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  clut_dac u_clut_dac (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .pix_fmt(pix_fmt), .pix_color(pix_color)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected packing, written from the requirement bit layouts
  function automatic logic [31:0] expect_pix(logic [1:0] fmt, logic [23:0] c);
    logic [7:0] r, g, b;
    {r, g, b} = c;
    case (fmt)
      2'd0:    return {24'h0, r[7:5], g[7:5], b[7:6]};
      2'd1:    return {17'h0, r[7:3], g[7:3], b[7:3]};
      2'd2:    return {16'h0, r[7:3], g[7:2], b[7:3]};
      default: return {8'h0, r, g, b};
    endcase
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_index(logic [7:0] i);
    bus_write(4'h0, {i, 24'hA5C3E1});
  endtask

  task automatic put_comp(logic [7:0] v);
    bus_write(4'h4, {v, 24'h5A3C1E});
  endtask

  task automatic lookup(logic [7:0] i, logic [1:0] f, output logic [31:0] v);
    @(negedge clk);
    pix_idx = i; pix_fmt = f;
    @(posedge clk); #1;
    v = pix_color;
  endtask

  task automatic expect_entry(string req, logic [7:0] i, logic [23:0] c);
    logic [31:0] v;
    lookup(i, 2'd3, v);
    chk(req, v, expect_pix(2'd3, c));
  endtask

  task automatic t_reset;
    chk("R1 pix_color in reset", pix_color, 32'h0);
    expect_entry("R1 entry0 black", 8'd0, 24'h0);
    expect_entry("R1 entry1 black", 8'd1, 24'h0);
    expect_entry("R1 entry128 black", 8'd128, 24'h0);
    expect_entry("R1 entry254 black", 8'd254, 24'h0);
    expect_entry("R1 entry255 white", 8'd255, 24'hFFFFFF);
  endtask

  task automatic t_load_rgb;
    set_index(8'd5);
    put_comp(8'h12); put_comp(8'h34); put_comp(8'h56);
    expect_entry("R3 entry5 rgb order", 8'd5, 24'h123456);
    expect_entry("R3 entry6 untouched", 8'd6, 24'h0);
  endtask

  task automatic t_auto_inc;
    set_index(8'd254);
    put_comp(8'h11); put_comp(8'h12); put_comp(8'h13);
    put_comp(8'h21); put_comp(8'h22); put_comp(8'h23);
    put_comp(8'h31); put_comp(8'h32); put_comp(8'h33);
    expect_entry("R4 entry254", 8'd254, 24'h111213);
    expect_entry("R4 entry255 after increment", 8'd255, 24'h212223);
    expect_entry("R4 entry0 after wrap", 8'd0, 24'h313233);
    expect_entry("R4 entry1 untouched", 8'd1, 24'h0);
  endtask

  task automatic t_index_restart;
    set_index(8'd40);
    put_comp(8'h50);
    set_index(8'd40);
    put_comp(8'h60); put_comp(8'h70); put_comp(8'h80);
    expect_entry("R2 index write restarts at red", 8'd40, 24'h607080);
  endtask

  task automatic t_addr_decode;
    set_index(8'd60);
    bus_write(4'h5, {8'hA1, 24'h0});
    bus_write(4'h6, {8'hA2, 24'hFFFFFF});
    bus_write(4'h7, {8'hA3, 24'h0});
    expect_entry("R2 low address bits ignored", 8'd60, 24'hA1A2A3);
    bus_write(4'h3, {8'd70, 24'h0});
    put_comp(8'hB1); put_comp(8'hB2); put_comp(8'hB3);
    expect_entry("R2 index via address 3", 8'd70, 24'hB1B2B3);
  endtask

  task automatic t_spare_regs;
    set_index(8'd50);
    put_comp(8'h11);
    bus_write(4'h8, 32'hFF00_0000);
    chk("R5 read data zero", bus_rdata, 32'h0);
    bus_write(4'hC, 32'hEE00_0000);
    bus_write(4'hB, 32'h0700_0000);
    put_comp(8'h22); put_comp(8'h33);
    expect_entry("R5 spare writes leave sequence", 8'd50, 24'h112233);
    expect_entry("R5 spare writes leave entry7", 8'd7, 24'h0);
    expect_entry("R5 spare writes leave entry255", 8'd255, 24'h212223);
    chk("R5 read data zero later", bus_rdata, 32'h0);
  endtask

  task automatic t_formats;
    logic [31:0] v;
    set_index(8'd9);
    put_comp(8'hB6); put_comp(8'h5D); put_comp(8'hE9);
    lookup(8'd9, 2'd0, v); chk("R6 8-bit pack", v, expect_pix(2'd0, 24'hB65DE9));
    lookup(8'd9, 2'd1, v); chk("R7 15-bit pack", v, expect_pix(2'd1, 24'hB65DE9));
    lookup(8'd9, 2'd2, v); chk("R8 16-bit pack", v, expect_pix(2'd2, 24'hB65DE9));
    lookup(8'd9, 2'd3, v); chk("R9 32-bit pack", v, expect_pix(2'd3, 24'hB65DE9));
    lookup(8'd40, 2'd0, v); chk("R6 8-bit pack entry40", v, expect_pix(2'd0, 24'h607080));
    lookup(8'd40, 2'd1, v); chk("R7 15-bit pack entry40", v, expect_pix(2'd1, 24'h607080));
    lookup(8'd40, 2'd2, v); chk("R8 16-bit pack entry40", v, expect_pix(2'd2, 24'h607080));
    set_index(8'd128);
    put_comp(8'hFF); put_comp(8'hFF); put_comp(8'hFF);
    lookup(8'd128, 2'd0, v); chk("R6 8-bit white", v, 32'h0000_00FF);
    lookup(8'd128, 2'd1, v); chk("R7 15-bit white", v, 32'h0000_7FFF);
    lookup(8'd128, 2'd2, v); chk("R8 16-bit white", v, 32'h0000_FFFF);
    lookup(8'd128, 2'd3, v); chk("R9 32-bit white", v, 32'h00FF_FFFF);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    lookup(8'd5, 2'd3, v);
    chk("R10 first lookup", v, 32'h0012_3456);
    @(negedge clk);
    pix_idx = 8'd9;
    #1;
    chk("R10 output unchanged before edge", pix_color, 32'h0012_3456);
    @(posedge clk); #1;
    chk("R10 output after one edge", pix_color, 32'h00B6_5DE9);
    @(posedge clk); #1;
    chk("R10 output holds", pix_color, 32'h00B6_5DE9);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_in_progress();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_load_rgb;
    t_auto_inc;
    t_index_restart;
    t_addr_decode;
    t_spare_regs;
    t_formats;
    t_latency;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic t_reset_in_progress;
    chk("R1 output cleared by reset", pix_color, 32'h0);
    chk("R5 read data zero in reset", bus_rdata, 32'h0);
  endtask

endmodule